// File: doc/BRIEF.md
# Programmable Quadrature Pulse Generator

This block produces two square waves, phase A and phase B, that stay a quarter cycle apart. A chain of two programmable dividers sets the rate. The first stage divides the system clock by (P+1). The second stage divides the first stage's rising edges by (C+1). The result is a stream of phase ticks, and the output frequency is f_clk / (16·(P+1)·(C+1)). For example, a 40 MHz clock with P = C = 0 gives 2.5 MHz.

Two single-bit phase counters count the phase ticks. Both start from reset at the same moment, preloaded one count apart. Each counter flips its output each time it reaches its compare value, so A and B alternate, and exactly one of them changes on each tick. The direction input swaps the compare value of the phase counters, which selects whether A leads B or B leads A.

When enable is low, every counter freezes and both outputs hold their levels. A new divider value is picked up only when its stage next reloads, so the period that is already running always completes with its old length.

Top module: `quad_pulse_gen`

## Requirements
- R1: While reset is held, both outputs are low. On the first clock edge with enable high after reset, the first phase tick occurs: phase A rises (direction 0) or phase B rises (direction 1).
- R2: With enable held high, phase ticks occur every 4·(P+1)·(C+1) clock edges, starting from the first enabled edge. Each output therefore has a period of 16·(P+1)·(C+1) clocks.
- R3: With direction = 0, the pair {A,B} steps through the cycle 00 → 10 → 11 → 01 → 00, one step per phase tick, so A leads B by a quarter cycle.
- R4: With direction = 1, the pair {A,B} steps through the cycle 00 → 01 → 11 → 10 → 00, one step per phase tick, so B leads A.
- R5: No clock edge changes both outputs at once.
- R6: A clock edge with enable low changes neither output and advances no counter. Timing resumes from the same point when enable returns high.
- R7: A new P or C is loaded only when its stage reloads after reaching zero. For example, with P=0 and C=3, changing C to 0 right after the first tick moves the second tick to the 11th enabled edge. Without the change it would fall on the 17th enabled edge.
- R8: A change of direction takes effect at the next phase tick. The sequence continues from the present state in the new order, with no step skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable; low freezes all counters |
| pre_div | input | PRE_W | Prescaler reload value P (divide by P+1) |
| per_div | input | PER_W | Period stage reload value C (divide by C+1) |
| dir | input | 1 | 0: A leads B; 1: B leads A |
| phase_a | output | 1 | Quadrature output A |
| phase_b | output | 1 | Quadrature output B |

## Verification
The assertions assume that the direction input is a clean synchronous level that is sampled at the same edge as the phase tick it steers. They also assume that reset is applied before any clock edge that matters. The bench meets both assumptions by changing enable, direction and the divider values only on falling clock edges, and by holding reset low from time zero. The random trials keep P and C small so that many full quadrature cycles fit into each run. Directed cases cover a divider change in the middle of a period and a reversal in the middle of a cycle.

// File: rtl/qg_pkg.sv
package qg_pkg;

    // State of the two phase counters and their output levels
    typedef struct packed {
        logic cnt_a;
        logic cnt_b;
        logic lvl_a;
        logic lvl_b;
    } phase_st_t;

    // Preloads one count apart so the two outputs interleave
    localparam logic CNT_A_INIT = 1'b1;
    localparam logic CNT_B_INIT = 1'b0;

    // Compare value of the phase counters for each direction
    function automatic logic fire_value(input logic reverse);
        return reverse ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/qg_div_stage.sv
// One programmable divide stage: a down-counter that reloads from
// `reload` after reaching zero and flips its level on every reload.
// `rise` pulses in the cycle whose edge drives the level from 0 to 1.
module qg_div_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    input  logic [W-1:0] reload,
    output logic         rise
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         lvl;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    adv;
    logic    at_zero;

    always_comb begin
        st_d    = st_q;
        adv     = en && step;
        at_zero = (st_q.cnt == '0);
        rise    = adv && at_zero && !st_q.lvl;
        if (adv) begin
            if (at_zero) begin
                st_d.cnt = reload;
                st_d.lvl = !st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/qg_phase_pair.sv
// Two single-bit phase counters that are clocked by the period tick.
// Each one flips its output when its count equals the compare value.
module qg_phase_pair
    import qg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dir,
    output logic out_a,
    output logic out_b
);

    phase_st_t st_d, st_q;
    logic      cmp;
    logic      hit_a;
    logic      hit_b;

    always_comb begin
        st_d  = st_q;
        cmp   = fire_value(dir);
        hit_a = (st_q.cnt_a == cmp);
        hit_b = (st_q.cnt_b == cmp);
        if (tick) begin
            st_d.cnt_a = !st_q.cnt_a;
            st_d.cnt_b = !st_q.cnt_b;
            if (hit_a) st_d.lvl_a = !st_q.lvl_a;
            if (hit_b) st_d.lvl_b = !st_q.lvl_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt_a <= CNT_A_INIT;
            st_q.cnt_b <= CNT_B_INIT;
            st_q.lvl_a <= 1'b0;
            st_q.lvl_b <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_a = st_q.lvl_a;
    assign out_b = st_q.lvl_b;

endmodule

// File: rtl/quad_pulse_gen.sv
module quad_pulse_gen #(
    parameter int PRE_W = 16,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre_div,
    input  logic [PER_W-1:0] per_div,
    input  logic             dir,
    output logic             phase_a,
    output logic             phase_b
);

    logic pre_rise;
    logic per_rise;

    qg_div_stage #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .step   (1'b1),
        .reload (pre_div),
        .rise   (pre_rise)
    );

    qg_div_stage #(.W(PER_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .step   (pre_rise),
        .reload (per_div),
        .rise   (per_rise)
    );

    qg_phase_pair u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (per_rise),
        .dir   (dir),
        .out_a (phase_a),
        .out_b (phase_b)
    );

endmodule

// File: rtl/quad_pulse_gen_chk.sv
module quad_pulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic dir,
    input logic phase_a,
    input logic phase_b
);

    // R1
    reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!phase_a && !phase_b));

    // R5
    one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({phase_a, phase_b} ^ $past({phase_a, phase_b})) <= 1);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(phase_a) && $stable(phase_b)));

    // R3
    fwd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_a != $past(phase_a)) && !$past(dir))
            |-> ($past(phase_a) == $past(phase_b)));

    // R4
    rev_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_b != $past(phase_b)) && $past(dir))
            |-> ($past(phase_a) == $past(phase_b)));

endmodule

bind quad_pulse_gen quad_pulse_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .dir     (dir),
    .phase_a (phase_a),
    .phase_b (phase_b)
);

// File: tb/quad_pulse_gen_bench.sv
module quad_pulse_gen_bench;

    localparam int PW = 16;
    localparam int CW = 16;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          en    = 1'b0;
    logic          dir   = 1'b0;
    logic [PW-1:0] pre   = '0;
    logic [CW-1:0] per   = '0;
    logic          a;
    logic          b;

    int tests = 0;
    int fails = 0;
    int n     = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    quad_pulse_gen #(.PRE_W(PW), .PER_W(CW)) u_quad_pulse_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .pre_div (pre),
        .per_div (per),
        .dir     (dir),
        .phase_a (a),
        .phase_b (b)
    );

    // Expected {A,B} after n enabled edges with fixed dir (R1..R4)
    function automatic logic [1:0] exp_state(int cnt, int nn, logic d);
        int t;
        if (cnt == 0) return 2'b00;
        t = ((cnt - 1) / (4 * nn) + 1) % 4;
        case (t)
            1:       return d ? 2'b01 : 2'b10;
            2:       return 2'b11;
            3:       return d ? 2'b10 : 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(string req, logic [1:0] exp);
        tests++;
        if ({a, b} !== exp) begin
            fails++;
            $display("FAIL %s: n=%0d got %b expected %b", req, n, {a, b}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n     = 0;
    endtask

    // Drive enable for one edge, return at the following falling edge
    task automatic cyc(logic e);
        en = e;
        @(negedge clk);
        if (e) n++;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));

        // R1: reset state, then first enabled edge
        pre = 0; per = 0; dir = 0;
        @(negedge clk);
        check("R1", 2'b00);
        do_reset();
        cyc(1'b0); cyc(1'b0);
        check("R1", 2'b00);
        cyc(1'b1);
        check("R1", 2'b10);

        // R2: larger dividers, tick boundaries at 72 enabled edges
        pre = 5; per = 2; dir = 0;
        do_reset();
        for (int i = 0; i < 80; i++) begin
            cyc(1'b1);
            if (n == 72) check("R2", 2'b10);
            if (n == 73) check("R2", 2'b11);
        end

        // R7: C change lands at the next reload only
        pre = 0; per = 3; dir = 0;
        do_reset();
        cyc(1'b1);
        check("R7", 2'b10);
        per = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1'b1);
            if (n == 10) check("R7", 2'b10);
            if (n == 11) check("R7", 2'b11);
        end

        // R8: reverse after the first forward step
        pre = 0; per = 0; dir = 0;
        do_reset();
        cyc(1'b1);
        check("R8", 2'b10);
        dir = 1;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1);
            if (n == 5)  check("R8", 2'b00);
            if (n == 9)  check("R8", 2'b01);
            if (n == 13) check("R8", 2'b11);
        end

        // Random trials: R2, R3, R4, R5, R6
        for (int tr = 0; tr < 16; tr++) begin
            logic [1:0] prev;
            int nn;
            pre = PW'($urandom % 4);
            per = CW'($urandom % 4);
            dir = ($urandom % 2) != 0;
            nn  = (int'(pre) + 1) * (int'(per) + 1);
            do_reset();
            prev = 2'b00;
            for (int i = 0; i < 300; i++) begin
                cyc(($urandom % 4) != 0);
                if (dir) check("R4 R2 R6", exp_state(n, nn, dir));
                else     check("R3 R2 R6", exp_state(n, nn, dir));
                tests++;
                if ($countones({a, b} ^ prev) > 1) begin
                    fails++;
                    $display("FAIL R5: got %b after %b expected one change at most",
                             {a, b}, prev);
                end
                prev = {a, b};
            end
        end

        summary();
    end

endmodule